// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Port

This peripheral gives a processor a set of general-purpose I/O ports, two 8-bit ports by default, behind a byte-wide register bus. Each port has seven registers. They hold the synchronized pin level, the output value, the direction, the latched edge flags, the edge polarity, the interrupt enables and a function-select byte that is passed out to surrounding logic. Every register bit belongs to one pin, and no bit affects any other.

Each pin input passes through a two-flop synchronizer. The synchronized level is compared with its value one clock earlier. When the polarity bit selects rising and the pin rises, or selects falling and the pin falls, the pin's flag is set. The flag then stays set until software writes a 0 to it. Software can also write a 1 to a flag to raise an interrupt without any pin activity. Each port raises its own request line on a 16-line interrupt vector whenever an enabled flag is set.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every writable register reads 0, `irq_line` is 0 and `pin_oe`, `pin_out` and `pin_fsel` are all 0.
- R2: Port 0 registers sit at byte addresses 0x20 to 0x26 and port 1 registers at 0x28 to 0x2E. Within a port, offset 0 is the pin level, 1 the output value, 2 the direction, 3 the flags, 4 the edge polarity, 5 the enables and 6 the function select. Offsets 1, 2, 4, 5 and 6 read back what was written. Addresses 0x27 and 0x2F read 0.
- R3: Offset 0 returns each pin's input after two clock edges of synchronization.
- R4: With polarity bit 0, a rising pin sets its flag by the third clock edge after the change. A falling pin leaves the flag unchanged.
- R5: With polarity bit 1, a falling pin sets its flag. A rising pin leaves the flag unchanged.
- R6: A set flag stays set across reads and further edges. Writing 0 to a flag bit clears only that bit.
- R7: Writing 1 to a flag bit sets that flag, whatever the pin is doing.
- R8: If an edge is detected on a pin in the same cycle that software writes 0 to that pin's flag, the flag ends up set.
- R9: A port's request is high exactly while some bit of (flags AND enables) is 1. With enables at 0, flags still latch but no request is raised.
- R10: Port p drives `irq_line[2+p]`. All other lines of the 16-bit vector stay 0.
- R11: For each pin, `pin_oe` equals its direction bit and `pin_out` equals output bit AND direction bit. `pin_fsel` equals the function-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 16 | Raw pin inputs, port p in bits [8p+7:8p] |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| pin_fsel | output | 16 | Function-select register contents |
| irq_line | output | 16 | Interrupt request vector |

## Verification
The bench builds the block with its defaults: two 8-bit ports, base address 0x20, a port stride of 8, two synchronizer stages and requests starting at line 2 of 16. These values let the bench reach both ports, the unmapped gap address after each port, and the placement of both request lines within the vector. They also make the three-edge latency from a pin change to a set flag a fixed count. The bench uses that count to place a flag-clearing write in the same cycle as a detected edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    REG_LEVEL   = 3'd0,
    REG_DRIVE   = 3'd1,
    REG_DIR     = 3'd2,
    REG_FLAG    = 3'd3,
    REG_EDGESEL = 3'd4,
    REG_ENABLE  = 3'd5,
    REG_FUNC    = 3'd6
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         we,
  input  reg_idx_e     idx,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] fsel,
  output logic [W-1:0] edge_evt,
  output logic [W-1:0] flag,
  output logic [W-1:0] enable,
  output logic         flag_wr,
  output logic         irq
);
  // per-pin edge match: polarity 0 selects rising, 1 selects falling
  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] cur,
                                             input logic [W-1:0] prev,
                                             input logic [W-1:0] fall_sel);
    return (cur & ~prev & ~fall_sel) | (~cur & prev & fall_sel);
  endfunction

  // hardware sets always survive a software write on the same cycle
  function automatic logic [W-1:0] flag_next(input logic [W-1:0] cur,
                                             input logic [W-1:0] hw,
                                             input logic         wr,
                                             input logic [W-1:0] wd);
    return hw | (wr ? wd : cur);
  endfunction

  logic [W-1:0] level, level_d;
  logic [W-1:0] drive_q, dir_q, pol_q, en_q, func_q, flag_q;
  logic         wr;

  gpio_sync #(.W(W), .STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (level)
  );

  assign wr       = sel & we;
  assign flag_wr  = wr && (idx == REG_FLAG);
  assign edge_evt = edge_hits(level, level_d, pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d <= '0;
      drive_q <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      func_q  <= '0;
      flag_q  <= '0;
    end else begin
      level_d <= level;
      flag_q  <= flag_next(flag_q, edge_evt, flag_wr, wdata);
      if (wr) begin
        case (idx)
          REG_DRIVE:   drive_q <= wdata;
          REG_DIR:     dir_q   <= wdata;
          REG_EDGESEL: pol_q   <= wdata;
          REG_ENABLE:  en_q    <= wdata;
          REG_FUNC:    func_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (idx)
        REG_LEVEL:   rdata = level;
        REG_DRIVE:   rdata = drive_q;
        REG_DIR:     rdata = dir_q;
        REG_FLAG:    rdata = flag_q;
        REG_EDGESEL: rdata = pol_q;
        REG_ENABLE:  rdata = en_q;
        REG_FUNC:    rdata = func_q;
        default:     rdata = '0;
      endcase
    end
  end

  assign pad_out = drive_q & dir_q;
  assign pad_oe  = dir_q;
  assign fsel    = func_q;
  assign flag    = flag_q;
  assign enable  = en_q;
  assign irq     = |(flag_q & en_q);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS      = 2,
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 32,
  parameter int PORT_STRIDE = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_LINES   = 16,
  parameter int IRQ_BASE    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [WIDTH-1:0]         bus_wdata,
  output logic [WIDTH-1:0]         bus_rdata,
  input  logic [NPORTS*WIDTH-1:0]  pin_in,
  output logic [NPORTS*WIDTH-1:0]  pin_out,
  output logic [NPORTS*WIDTH-1:0]  pin_oe,
  output logic [NPORTS*WIDTH-1:0]  pin_fsel,
  output logic [IRQ_LINES-1:0]     irq_line
);
  localparam int PW = NPORTS * WIDTH;

  // named internal events, observed by the bound checker
  logic [PW-1:0]     edge_evt_all;
  logic [PW-1:0]     flag_all;
  logic [PW-1:0]     enable_all;
  logic [NPORTS-1:0] flag_wr_all;
  logic [NPORTS-1:0] port_irq;
  logic [WIDTH-1:0]  port_rd [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] PBASE = ADDR_W'(BASE_ADDR + p * PORT_STRIDE);
    logic [ADDR_W-1:0] off;
    logic              hit;

    assign off = bus_addr - PBASE;
    assign hit = off < ADDR_W'(NUM_REGS);

    gpio_port #(.W(WIDTH), .SYNC(SYNC_STAGES)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (hit),
      .we      (bus_we),
      .idx     (reg_idx_e'(off[2:0])),
      .wdata   (bus_wdata),
      .pin_raw (pin_in[p*WIDTH +: WIDTH]),
      .rdata   (port_rd[p]),
      .pad_out (pin_out[p*WIDTH +: WIDTH]),
      .pad_oe  (pin_oe[p*WIDTH +: WIDTH]),
      .fsel    (pin_fsel[p*WIDTH +: WIDTH]),
      .edge_evt(edge_evt_all[p*WIDTH +: WIDTH]),
      .flag    (flag_all[p*WIDTH +: WIDTH]),
      .enable  (enable_all[p*WIDTH +: WIDTH]),
      .flag_wr (flag_wr_all[p]),
      .irq     (port_irq[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORTS; p++) bus_rdata = bus_rdata | port_rd[p];
  end

  for (genvar l = 0; l < IRQ_LINES; l++) begin : g_line
    if (l >= IRQ_BASE && l < IRQ_BASE + NPORTS) begin : g_used
      assign irq_line[l] = port_irq[l-IRQ_BASE];
    end else begin : g_spare
      assign irq_line[l] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NP        = 2,
  parameter int W         = 8,
  parameter int IRQ_LINES = 16,
  parameter int IRQ_BASE  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NP*W-1:0]      edge_evt,
  input logic [NP*W-1:0]      flag,
  input logic [NP*W-1:0]      enable,
  input logic [NP-1:0]        flag_wr,
  input logic [W-1:0]         wdata,
  input logic [IRQ_LINES-1:0] irq_line
);
  for (genvar g = 0; g < NP*W; g++) begin : g_bit
    localparam int P = g / W;
    localparam int B = g % W;

    assert_edge_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[g] |=> flag[g]);

    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flag[g] && !edge_evt[g] && !(flag_wr[P] && wdata[B]) |=> !flag[g]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag[g] && !flag_wr[P] |=> flag[g]);

    assert_soft_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr[P] && wdata[B] |=> flag[g]);

    assert_hw_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[g] && flag_wr[P] && !wdata[B] |=> flag[g]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_req
    assert_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line[IRQ_BASE+p] == |(flag[p*W +: W] & enable[p*W +: W]));
  end
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NP(NPORTS), .W(WIDTH), .IRQ_LINES(IRQ_LINES), .IRQ_BASE(IRQ_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .edge_evt(edge_evt_all),
  .flag    (flag_all),
  .enable  (enable_all),
  .flag_wr (flag_wr_all),
  .wdata   (bus_wdata),
  .irq_line(irq_line)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_fsel, irq_line;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq_line, 2 pin_out, 3 pin_oe, 4 pin_fsel
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_fsel(pin_fsel), .irq_line(irq_line)
  );

  // monitor: pops expectations and compares against the live outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = {8'h00, bus_rdata};
          1: act = irq_line;
          2: act = pin_out;
          3: act = pin_oe;
          default: act = pin_fsel;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    #1;
    it.kind = 0; it.exp = {8'h00, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_sig(input int k, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 8'h21; a <= 8'h26; a++) exp_rd(8'(a), 8'h00, "R1 port0 reg reset");
    for (int a = 8'h29; a <= 8'h2E; a++) exp_rd(8'(a), 8'h00, "R1 port1 reg reset");
    exp_sig(1, 16'h0000, "R1 irq_line reset");
    exp_sig(3, 16'h0000, "R1 pin_oe reset");
    exp_sig(2, 16'h0000, "R1 pin_out reset");

    // R2: map and readback
    wr(8'h21, 8'hA5); wr(8'h22, 8'h0F); wr(8'h26, 8'h33);
    wr(8'h29, 8'h5A); wr(8'h2A, 8'hF0); wr(8'h2E, 8'hC3);
    wr(8'h24, 8'h96); wr(8'h2D, 8'h69);
    exp_rd(8'h21, 8'hA5, "R2 port0 out");
    exp_rd(8'h22, 8'h0F, "R2 port0 dir");
    exp_rd(8'h26, 8'h33, "R2 port0 func");
    exp_rd(8'h24, 8'h96, "R2 port0 polarity");
    exp_rd(8'h29, 8'h5A, "R2 port1 out");
    exp_rd(8'h2A, 8'hF0, "R2 port1 dir");
    exp_rd(8'h2E, 8'hC3, "R2 port1 func");
    exp_rd(8'h2D, 8'h69, "R2 port1 enable");
    exp_rd(8'h27, 8'h00, "R2 gap after port0");
    exp_rd(8'h2F, 8'h00, "R2 gap after port1");
    wr(8'h24, 8'h00); wr(8'h2D, 8'h00);

    // R11: pad outputs
    exp_sig(2, 16'h5005, "R11 pin_out");
    exp_sig(3, 16'hF00F, "R11 pin_oe");
    exp_sig(4, 16'hC333, "R11 pin_fsel");

    // R3 / R4 / R9: rising edges latch with enables off
    set_pins(16'h8142);
    exp_rd(8'h20, 8'h42, "R3 port0 level");
    exp_rd(8'h28, 8'h81, "R3 port1 level");
    exp_rd(8'h23, 8'h42, "R4 port0 rising flags");
    exp_rd(8'h2B, 8'h81, "R4 port1 rising flags");
    exp_sig(1, 16'h0000, "R9 no request with enables off");
    wr(8'h23, 8'h00); wr(8'h2B, 8'h00);
    set_pins(16'h0000);
    exp_rd(8'h23, 8'h00, "R4 falling ignored port0");
    exp_rd(8'h2B, 8'h00, "R4 falling ignored port1");

    // R5: falling polarity on port0
    wr(8'h24, 8'hFF);
    set_pins(16'h0001);
    exp_rd(8'h23, 8'h00, "R5 rising ignored");
    set_pins(16'h0000);
    exp_rd(8'h23, 8'h01, "R5 falling sets");

    // R6: sticky through reads and edges, per-bit clear
    set_pins(16'h0001);
    exp_rd(8'h23, 8'h01, "R6 sticky after rise");
    set_pins(16'h0000);
    exp_rd(8'h23, 8'h01, "R6 sticky after second fall");
    wr(8'h23, 8'h11);
    exp_rd(8'h23, 8'h11, "R7 soft set bit4");
    wr(8'h23, 8'h10);
    exp_rd(8'h23, 8'h10, "R6 clear bit0 only");
    wr(8'h23, 8'h00);
    exp_rd(8'h23, 8'h00, "R6 clear all");

    // R9 / R10: request lines
    wr(8'h2D, 8'h04);
    wr(8'h2B, 8'h02);
    exp_sig(1, 16'h0000, "R9 flag without enable");
    wr(8'h2B, 8'h06);
    exp_sig(1, 16'h0008, "R10 port1 on line 3");
    wr(8'h25, 8'h01);
    wr(8'h23, 8'h01);
    exp_sig(1, 16'h000C, "R10 both lines");
    wr(8'h2B, 8'h00);
    exp_sig(1, 16'h0004, "R10 port0 on line 2");
    wr(8'h23, 8'h00);
    exp_sig(1, 16'h0000, "R9 request drops");

    // R8: edge detected in the same cycle as a clearing write
    wr(8'h24, 8'h00);
    @(negedge clk);
    pin_in = 16'h0002;
    @(negedge clk);
    wr(8'h23, 8'h00);
    exp_rd(8'h23, 8'h02, "R8 hardware set wins");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule